// File: doc/BRIEF.md
# Bit-Serial Clock Synthesizer Programmer

This block programs an external frequency synthesizer whose programming pins hang off one byte-wide clock control register. Three bits of that byte matter to the serial protocol: a data bit, a serial clock bit and a strobe bit. Setting the strobe bit makes the external logic latch the register. Every update of the control byte comes out on `ctl_byte` together with a one-cycle `ctl_we` pulse.

A host pulses `start` with a 5-bit synthesizer location and a 13-bit program word. The block then runs the whole programming sequence by itself. It first clears the register and waits a settling guard time. It sends a short preamble and then a 21-bit serial frame. Each bit is clocked low and then high, and each of those two steps is followed by a timed strobe. The block then restores the control byte it held before the run, with the strobe bit set. After a long guard time it selects the programmed location. All waits are given in microseconds and converted to clock cycles from the `CLK_HZ` parameter. Computing the program word is left to the host.

Top module: `synth_clock_loader`

## Requirements
- R1: During and after reset, `ctl_byte` is 0 and `busy`, `done` and `ctl_we` are low.
- R2: A `start` seen while idle makes `busy` high from the next cycle until the cycle of the final write. A `start` seen while busy has no effect on the run in progress.
- R3: The first write of a run sets the control byte to 0x00. The next write follows after the settling guard time (SETTLE_US).
- R4: The preamble writes 0x00, then 0x40, then 0x01, then 0x41. The strobe bit is bit 6 (0x40).
- R5: Each frame bit takes four writes. First the data value goes to bit 2 with bit 3 cleared. Then the strobe bit 6 is set. Then bit 3 is set. Then the strobe bit is set again. Other bits keep their values.
- R6: The 21 frame bits go out in this order: 1, 0, 0, then the five location bits least significant first, then the thirteen program-word bits least significant first.
- R7: TAIL_US after the last frame strobe, the block writes the control byte it held before the run, with bit 6 set.
- R8: SELECT_US after the restore, the block writes the low 4 location bits in bits 3:0 with bit 6 set and the other bits 0. `done` is high for exactly that one cycle, together with that write.
- R9: `ctl_byte` changes only in cycles where `ctl_we` is high. A run makes exactly 91 writes.
- R10: Each write that sets the strobe in the preamble or the frame comes STROBE_US after the write before it. Every wait lasts ceil(CLK_HZ*us/1e6) cycles, with a minimum of 1, measured from the write before it. All other writes in a run follow one cycle after the previous write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a programming run (used only while idle) |
| loc_addr | input | 5 | Synthesizer location to program and select |
| prog_word | input | 13 | Program word to shift out |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse with the final write |
| ctl_byte | output | 8 | Current control register value |
| ctl_we | output | 1 | Pulses when ctl_byte is updated |

## Verification
The bench replays the full write stream for locations and words that include all-zero, all-one and alternating patterns, and compares both the value and the cycle gap of every write. A design that sent the location or the word most significant bit first, or dropped the leading 1 of the preamble, would show wrong bit 2 values at exact frame positions. Wrong clear-before-set ordering of the serial clock would show on bit 3. A design that restored 0 instead of the previous run's final byte is caught, because consecutive runs end with different select bytes. A start pulse injected mid-run, with inverted data, shows that a design which re-latches would corrupt the rest of the stream. Off-by-one waits show as gaps one cycle too long or too short.

// File: rtl/synth_pkg.sv
// Package: shared phase encoding and delay conversion for the synthesizer
// programmer. Assumes delays are whole microseconds and the clock is given in Hz.
package synth_pkg;

    // Sequencer phases; PH_WAIT returns to the phase held in a return register.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_WAIT,
        PH_ZERO,
        PH_ZERO_STB,
        PH_ONE,
        PH_ONE_STB,
        PH_BIT_LO,
        PH_BIT_LO_STB,
        PH_BIT_HI,
        PH_BIT_HI_STB,
        PH_RESTORE,
        PH_SELECT
    } phase_t;

    // Convert a microsecond delay to clock cycles, rounded up, at least one.
    function automatic longint wait_cycles(input longint hz, input longint us);
        longint c;
        c = (hz * us + 64'd999999) / 64'd1000000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/synth_wait_timer.sv
// Module: one-shot down-counter used for every timed wait.
// Assumes load_val >= 1 and that load is never asserted while fire is high.
// fire rises in the cycle load_val cycles after the load edge.
module synth_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Count down from load_val-1 and stop when zero is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expiry indication for the sequencer.
    always_comb fire = run_q && (cnt_q == '0);

endmodule

// File: rtl/synth_frame_pack.sv
// Module: assembles the serial frame in transmit order (index 0 goes first).
// Layout: lead-in one, start zero, write-select zero, location bits LSB first,
// then program-word bits LSB first. Purely combinational.
module synth_frame_pack #(
    parameter int ADDR_W    = 5,
    parameter int WORD_W    = 13,
    parameter int FRAME_LEN = 3 + ADDR_W + WORD_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    word,
    output logic [FRAME_LEN-1:0] frame
);

    localparam int HDR_LEN = 3;

    // Fixed header: one, start zero, write-select zero.
    assign frame[0] = 1'b1;
    assign frame[1] = 1'b0;
    assign frame[2] = 1'b0;

    // Location field, least significant bit sent first.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        assign frame[HDR_LEN + i] = addr[i];
    end

    // Program-word field, least significant bit sent first.
    for (genvar j = 0; j < WORD_W; j++) begin : g_word
        assign frame[HDR_LEN + ADDR_W + j] = word[j];
    end

endmodule

// File: rtl/synth_prog_seq.sv
// Module: phase sequencer that issues every control-register write of a run.
// Each phase makes one write. A phase that ends in a wait loads the timer,
// parks in PH_WAIT and resumes at the saved return phase once the timer fires.
// Assumes the frame, location and previous control byte are latched at start.
module synth_prog_seq
    import synth_pkg::*;
#(
    parameter int     ADDR_W    = 5,
    parameter int     FRAME_LEN = 21,
    parameter int     CTL_W     = 8,
    parameter int     DATA_POS  = 2,
    parameter int     SCLK_POS  = 3,
    parameter int     STB_POS   = 6,
    parameter int     SEL_W     = 4,
    parameter int     TMR_W     = 16,
    parameter longint CYC_STB   = 3,
    parameter longint CYC_SETTLE= 100,
    parameter longint CYC_TAIL  = 10,
    parameter longint CYC_SEL   = 300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 tmr_fire,
    output logic                 tmr_load,
    output logic [TMR_W-1:0]     tmr_val,
    output logic                 busy,
    output logic                 done,
    output logic [CTL_W-1:0]     ctl_byte,
    output logic                 ctl_we
);

    localparam int              IDX_W  = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CTL_W-1:0] M_DATA = CTL_W'(1) << DATA_POS;
    localparam logic [CTL_W-1:0] M_SCLK = CTL_W'(1) << SCLK_POS;
    localparam logic [CTL_W-1:0] M_STB  = CTL_W'(1) << STB_POS;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    phase_t                 phase_q, ret_q;
    logic [IDX_W-1:0]       idx_q;
    logic [FRAME_LEN-1:0]   frame_q;
    logic [CTL_W-1:0]       saved_q;
    logic [SEL_W-1:0]       sel_q;
    logic [CTL_W-1:0]       ctl_q;
    logic                   we_q;
    logic                   done_q;

    logic                   wr_en;
    logic [CTL_W-1:0]       wr_val;
    logic                   has_wait;
    logic [TMR_W-1:0]       wait_len;
    phase_t                 after_ph;
    logic                   cur_bit;

    // Bit currently being shifted out.
    always_comb cur_bit = frame_q[idx_q];

    // Decode the write, the following wait and the next phase for this cycle.
    always_comb begin
        wr_en    = 1'b0;
        wr_val   = ctl_q;
        has_wait = 1'b0;
        wait_len = TMR_W'(1);
        after_ph = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                after_ph = PH_IDLE;
            end
            PH_CLEAR: begin
                wr_en    = 1'b1;
                wr_val   = '0;
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_SETTLE);
                after_ph = PH_ZERO;
            end
            PH_ZERO: begin
                wr_en    = 1'b1;
                wr_val   = '0;
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_STB);
                after_ph = PH_ZERO_STB;
            end
            PH_ZERO_STB: begin
                wr_en    = 1'b1;
                wr_val   = ctl_q | M_STB;
                after_ph = PH_ONE;
            end
            PH_ONE: begin
                wr_en    = 1'b1;
                wr_val   = CTL_W'(1);
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_STB);
                after_ph = PH_ONE_STB;
            end
            PH_ONE_STB: begin
                wr_en    = 1'b1;
                wr_val   = ctl_q | M_STB;
                after_ph = PH_BIT_LO;
            end
            PH_BIT_LO: begin
                wr_en    = 1'b1;
                wr_val   = (ctl_q & ~(M_DATA | M_SCLK)) | (cur_bit ? M_DATA : '0);
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_STB);
                after_ph = PH_BIT_LO_STB;
            end
            PH_BIT_LO_STB: begin
                wr_en    = 1'b1;
                wr_val   = ctl_q | M_STB;
                after_ph = PH_BIT_HI;
            end
            PH_BIT_HI: begin
                wr_en    = 1'b1;
                wr_val   = ctl_q | M_SCLK;
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_STB);
                after_ph = PH_BIT_HI_STB;
            end
            PH_BIT_HI_STB: begin
                wr_en    = 1'b1;
                wr_val   = ctl_q | M_STB;
                if (idx_q == LAST_IDX) begin
                    has_wait = 1'b1;
                    wait_len = TMR_W'(CYC_TAIL);
                    after_ph = PH_RESTORE;
                end else begin
                    after_ph = PH_BIT_LO;
                end
            end
            PH_RESTORE: begin
                wr_en    = 1'b1;
                wr_val   = saved_q | M_STB;
                has_wait = 1'b1;
                wait_len = TMR_W'(CYC_SEL);
                after_ph = PH_SELECT;
            end
            PH_SELECT: begin
                wr_en    = 1'b1;
                wr_val   = CTL_W'(sel_q) | M_STB;
                after_ph = PH_IDLE;
            end
            PH_WAIT: begin
                after_ph = tmr_fire ? ret_q : PH_WAIT;
            end
            default: begin
                after_ph = PH_IDLE;
            end
        endcase
    end

    // Phase register, return phase and run context captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ret_q   <= PH_IDLE;
            idx_q   <= '0;
            frame_q <= '0;
            saved_q <= '0;
            sel_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start) begin
                phase_q <= PH_CLEAR;
                idx_q   <= '0;
                frame_q <= frame;
                saved_q <= ctl_q;
                sel_q   <= addr[SEL_W-1:0];
            end
        end else begin
            if (has_wait) begin
                phase_q <= PH_WAIT;
                ret_q   <= after_ph;
            end else begin
                phase_q <= after_ph;
            end
            if (phase_q == PH_BIT_HI_STB && idx_q != LAST_IDX)
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Output register for the control byte with its write pulse and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            we_q   <= wr_en;
            done_q <= (phase_q == PH_SELECT);
            if (wr_en) ctl_q <= wr_val;
        end
    end

    // Timer handshake and status outputs.
    always_comb begin
        tmr_load = wr_en && has_wait;
        tmr_val  = wait_len;
        busy     = (phase_q != PH_IDLE);
        done     = done_q;
        ctl_byte = ctl_q;
        ctl_we   = we_q;
    end

endmodule

// File: rtl/synth_clock_loader.sv
// Module: top of the serial synthesizer programmer.
// Converts the microsecond delays to cycle counts, sizes the wait timer and
// wires the frame packer, the sequencer and the timer together.
// Assumes a free-running clk at CLK_HZ and a synchronous active-low reset.
module synth_clock_loader
    import synth_pkg::*;
#(
    parameter longint CLK_HZ    = 100_000_000,
    parameter longint STROBE_US = 26,
    parameter longint SETTLE_US = 15_000,
    parameter longint TAIL_US   = 1_000,
    parameter longint SELECT_US = 50_000,
    parameter int     ADDR_W    = 5,
    parameter int     WORD_W    = 13,
    parameter int     CTL_W     = 8,
    parameter int     DATA_POS  = 2,
    parameter int     SCLK_POS  = 3,
    parameter int     STB_POS   = 6,
    parameter int     SEL_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [WORD_W-1:0] prog_word,
    output logic              busy,
    output logic              done,
    output logic [CTL_W-1:0]  ctl_byte,
    output logic              ctl_we
);

    localparam int     FRAME_LEN  = 3 + ADDR_W + WORD_W;
    localparam longint CYC_STB    = wait_cycles(CLK_HZ, STROBE_US);
    localparam longint CYC_SETTLE = wait_cycles(CLK_HZ, SETTLE_US);
    localparam longint CYC_TAIL   = wait_cycles(CLK_HZ, TAIL_US);
    localparam longint CYC_SEL    = wait_cycles(CLK_HZ, SELECT_US);
    localparam longint CYC_MAX_A  = (CYC_STB > CYC_SETTLE) ? CYC_STB : CYC_SETTLE;
    localparam longint CYC_MAX_B  = (CYC_TAIL > CYC_SEL) ? CYC_TAIL : CYC_SEL;
    localparam longint CYC_MAX    = (CYC_MAX_A > CYC_MAX_B) ? CYC_MAX_A : CYC_MAX_B;
    localparam int     TMR_W      = $clog2(CYC_MAX + 1);

    logic [FRAME_LEN-1:0] frame;
    logic                 tmr_load;
    logic [TMR_W-1:0]     tmr_val;
    logic                 tmr_fire;

    synth_frame_pack #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_pack (
        .addr  (loc_addr),
        .word  (prog_word),
        .frame (frame)
    );

    synth_wait_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .fire     (tmr_fire)
    );

    synth_prog_seq #(
        .ADDR_W     (ADDR_W),
        .FRAME_LEN  (FRAME_LEN),
        .CTL_W      (CTL_W),
        .DATA_POS   (DATA_POS),
        .SCLK_POS   (SCLK_POS),
        .STB_POS    (STB_POS),
        .SEL_W      (SEL_W),
        .TMR_W      (TMR_W),
        .CYC_STB    (CYC_STB),
        .CYC_SETTLE (CYC_SETTLE),
        .CYC_TAIL   (CYC_TAIL),
        .CYC_SEL    (CYC_SEL)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr     (loc_addr),
        .frame    (frame),
        .tmr_fire (tmr_fire),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .busy     (busy),
        .done     (done),
        .ctl_byte (ctl_byte),
        .ctl_we   (ctl_we)
    );

endmodule

// File: rtl/synth_clock_loader_chk.sv
// Module: protocol checker for synth_clock_loader, bound to every instance.
// Observes ports only; assumes bit 6 of the control byte is the strobe.
module synth_clock_loader_chk #(
    parameter int CTL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CTL_W-1:0] ctl_byte,
    input logic             ctl_we
);

    // Reset values while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (ctl_byte == '0 && !busy && !done && !ctl_we); // R1
        end
    end

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_we && ctl_byte[6] && !busy)); // R8

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R2

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |-> $stable(ctl_byte)); // R9

    AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |-> (busy || done)); // R9

endmodule

bind synth_clock_loader synth_clock_loader_chk #(.CTL_W(CTL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ctl_byte (ctl_byte),
    .ctl_we   (ctl_we)
);

// File: tb/synth_clock_loader_test.sv
// Bench: replays every write of a run and compares value and cycle gap
// against a model built from the requirements.
module synth_clock_loader_test;

    localparam longint HZ  = 100_000;
    localparam int     FL  = 21;
    localparam int     NW  = 5 + 4 * FL + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  loc_addr = '0;
    logic [12:0] prog_word = '0;
    logic        busy, done, ctl_we;
    logic [7:0]  ctl_byte;

    int     nchk = 0;
    int     nerr = 0;
    longint cyc = 0;
    bit     rec_en = 1'b0;
    int     wv [0:127];
    longint wc [0:127];
    int     nw = 0;
    int     done_cnt = 0;
    longint done_cyc = 0;
    int     prev_last = 0;

    synth_clock_loader #(.CLK_HZ(HZ)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .loc_addr  (loc_addr),
        .prog_word (prog_word),
        .busy      (busy),
        .done      (done),
        .ctl_byte  (ctl_byte),
        .ctl_we    (ctl_we)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Write and done monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rec_en && ctl_we) begin
            if (nw < 128) begin
                wv[nw] = int'(ctl_byte);
                wc[nw] = cyc;
            end
            nw = nw + 1;
        end
        if (rec_en && done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    function automatic longint wcyc(input longint us);
        longint c;
        c = (HZ * us + 999999) / 1000000;
        if (c < 1) c = 1;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // One programming run; interfere injects a start pulse mid-run.
    task automatic run(input logic [4:0] a, input logic [12:0] w, input bit interfere);
        int xv [0:127];
        int xg [0:127];
        int n;
        int m;
        int b;
        int tmo;
        longint s_stb, s_set, s_tail, s_sel;
        s_stb  = wcyc(26);
        s_set  = wcyc(15000);
        s_tail = wcyc(1000);
        s_sel  = wcyc(50000);
        nw = 0;
        done_cnt = 0;
        rec_en = 1'b1;
        @(negedge clk);
        loc_addr  = a;
        prog_word = w;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        if (interfere) begin
            repeat (40) @(negedge clk);
            loc_addr  = ~a;
            prog_word = ~w;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R2 busy kept on ignored start", busy, 1);
        end
        tmo = 0;
        while (done_cnt == 0 && tmo < 20000) begin
            @(negedge clk);
            tmo = tmo + 1;
        end
        repeat (3) @(negedge clk);
        rec_en = 1'b0;
        check(busy == 1'b0, "R2 idle after done", busy, 0);
        check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);

        // Expected write stream.
        n = 0;
        xv[n] = 0;    xg[n] = 0;              n++;
        xv[n] = 0;    xg[n] = int'(s_set) + 1; n++;
        xv[n] = 8'h40; xg[n] = int'(s_stb) + 1; n++;
        xv[n] = 8'h01; xg[n] = 1;             n++;
        xv[n] = 8'h41; xg[n] = int'(s_stb) + 1; n++;
        m = 8'h41;
        for (int i = 0; i < FL; i++) begin
            if (i == 0)      b = 1;
            else if (i < 3)  b = 0;
            else if (i < 8)  b = int'(a[i-3]);
            else             b = int'(w[i-8]);
            m = (m & ~8'h0C) | (b << 2); xv[n] = m; xg[n] = 1; n++;
            m = m | 8'h40; xv[n] = m; xg[n] = int'(s_stb) + 1; n++;
            m = m | 8'h08; xv[n] = m; xg[n] = 1; n++;
            m = m | 8'h40; xv[n] = m; xg[n] = int'(s_stb) + 1; n++;
        end
        xv[n] = prev_last | 8'h40;            xg[n] = int'(s_tail) + 1; n++;
        xv[n] = int'(a[3:0]) | 8'h40;         xg[n] = int'(s_sel) + 1;  n++;

        check(nw == NW, "R9 write count", nw, NW);
        if (nw == NW) begin
            check(done_cyc == wc[NW-1], "R8 done with final write", done_cyc, wc[NW-1]);
            for (int k = 0; k < NW; k++) begin
                if (k == 0)
                    check(wv[k] == xv[k], "R3 clear write", wv[k], xv[k]);
                else if (k < 5)
                    check(wv[k] == xv[k], "R4 preamble write", wv[k], xv[k]);
                else if (k < NW - 2) begin
                    if ((k - 5) % 4 == 0)
                        check(wv[k] == xv[k], "R6 frame data bit", wv[k], xv[k]);
                    else
                        check(wv[k] == xv[k], "R5 bit clock/strobe write", wv[k], xv[k]);
                end
                else if (k == NW - 2)
                    check(wv[k] == xv[k], "R7 restore write", wv[k], xv[k]);
                else
                    check(wv[k] == xv[k], "R8 select write", wv[k], xv[k]);
                if (k > 0)
                    check((wc[k] - wc[k-1]) == longint'(xg[k]), "R10 write gap",
                          wc[k] - wc[k-1], xg[k]);
            end
        end
        prev_last = xv[NW-1];
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        nchk = nchk + 1;
        nerr = nerr + 1;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(ctl_byte == 8'h00, "R1 reset ctl_byte", ctl_byte, 0);
        check(!busy && !done && !ctl_we, "R1 reset flags", {busy, done, ctl_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_byte == 8'h00 && !busy, "R1 idle after reset", ctl_byte, 0);
        for (int i = 0; i < 15; i++) begin
            logic [4:0]  a;
            logic [12:0] w;
            if (i == 0)      begin a = 5'd0;  w = 13'h0000; end
            else if (i == 1) begin a = 5'd31; w = 13'h1FFF; end
            else if (i == 2) begin a = 5'h15; w = 13'h1555; end
            else if (i == 3) begin a = 5'h0A; w = 13'h0AAA; end
            else begin
                a = 5'((i * 7 + 3) % 32);
                w = 13'((i * 1237) % 8192) ^ (13'h1 << (i % 13));
            end
            run(a, w, i == 5);
        end
        finish_run();
    end

endmodule